// File: doc/BRIEF.md
# Serial Bus Hold Controller

This block pauses an active serial transfer whenever the bus master pulls an active-low hold input while the device is selected. While the pause lasts, the shift state, the bit counter and any partly assembled word are frozen. When the pause ends, the transfer resumes at the same bit position, as if no pause had occurred. A pause is useful when the serial clock and data lines are shared and another device needs the bus for a while.

The block runs on a system clock that oversamples the serial interface. Chip select, serial clock, hold and serial data each pass through a synchronizer chain. Edges are found by comparing successive synchronized samples.

A small four-state machine decides when the pause starts and when it ends, and this depends on the serial clock level:

- `ST_RUN`: normal transfer.
- `ST_START_WAIT`: a pause was requested with the clock high. The machine waits for the next clock falling edge.
- `ST_HELD`: paused.
- `ST_END_WAIT`: a release was requested with the clock high. The machine waits for the next clock falling edge.

The transitions are:

| Transition | Condition |
|---|---|
| `ST_RUN` -> `ST_HELD` | hold falls, device selected, clock low |
| `ST_RUN` -> `ST_START_WAIT` | hold falls, device selected, clock high |
| `ST_START_WAIT` -> `ST_HELD` | clock falls |
| `ST_START_WAIT` -> `ST_RUN` | hold rises before the clock falls (cancel) |
| `ST_HELD` -> `ST_RUN` | hold rises with the clock low |
| `ST_HELD` -> `ST_END_WAIT` | hold rises with the clock high |
| `ST_END_WAIT` -> `ST_RUN` | clock falls |
| `ST_END_WAIT` -> `ST_HELD` | hold falls before the clock falls (cancel) |
| any state -> `ST_RUN` | deselect |

The hold-active flag gates clock edges into a word shift register. That register is included only to show freeze and resume.

Top module: `sbus_hold_ctrl`

## Requirements
- R1: After reset, `hold_active`, `sdo_oe`, `rx_valid` and `bit_cnt` are all 0.
- R2: While selected (`cs_n_in`=0) with the serial clock low, a falling `hold_n_in` makes `hold_active` 1 within 4 system clocks.
- R3: If the serial clock is high when `hold_n_in` falls, `hold_active` stays 0 until the next serial clock falling edge, then becomes 1.
- R4: If the serial clock is low when `hold_n_in` rises during a pause, `hold_active` returns to 0 within 4 system clocks.
- R5: If the serial clock is high when `hold_n_in` rises during a pause, `hold_active` stays 1 until the next serial clock falling edge.
- R6: While `hold_active` is 1, serial clock rising edges and `sdi_in` are ignored: `bit_cnt` holds and no word completes. After release, the next rising edge fills the bit position that was frozen.
- R7: `sdo_oe` is 1 exactly when the device is selected and not paused. It changes in the same system clock cycle as `hold_active`.
- R8: While `quad_mode` is 1, a falling `hold_n_in` starts no pause.
- R9: Deselecting (`cs_n_in`=1) during a pause ends it and clears `bit_cnt` and the partial word.
- R10: A pending start is cancelled if `hold_n_in` rises again before the serial clock falls.
- R11: A pending release is cancelled if `hold_n_in` falls again before the serial clock falls, so the pause continues.
- R12: Data is shifted MSB first on serial clock rising edges. After `WORD_W` bits, `rx_byte` presents the word with a one-cycle `rx_valid` pulse and `bit_cnt` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_in | input | 1 | Active-low chip select, asynchronous |
| sck_in | input | 1 | Serial clock, asynchronous |
| hold_n_in | input | 1 | Active-low hold request, asynchronous |
| sdi_in | input | 1 | Serial data input |
| quad_mode | input | 1 | High while a four-lane transfer is in progress |
| hold_active | output | 1 | Pause in effect |
| sdo_oe | output | 1 | Output-enable for the serial data output; 0 means high impedance |
| sdo_out | output | 1 | Serial data output value (MSB of the shift register) |
| bit_cnt | output | $clog2(WORD_W) | Bit position of the next bit to be shifted |
| rx_byte | output | WORD_W | Last completed word |
| rx_valid | output | 1 | One-cycle pulse when a word completes |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and an 8-bit word. With these values, a paused word can be split at any position with only a few serial edges. A half serial period of six system clocks clears the three-cycle input latency, so each level-dependent start, release and cancel case can be set up deliberately with the serial clock parked high or low. A scoreboard holds the words expected after each interrupted transfer, and each completed word is compared against it.

// File: rtl/sbh_pkg.sv
package sbh_pkg;
    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_START_WAIT = 2'd1,
        ST_HELD       = 2'd2,
        ST_END_WAIT   = 2'd3
    } hold_state_t;
endpackage

// File: rtl/sbh_sync.sv
module sbh_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
        end
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/sbh_hold_fsm.sv
module sbh_hold_fsm
    import sbh_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_s,
    input  logic        sck_s,
    input  logic        sck_fall,
    input  logic        hold_fall,
    input  logic        hold_rise,
    input  logic        quad_mode,
    output hold_state_t state,
    output logic        hold_active,
    output logic        sdo_oe
);
    hold_state_t state_nxt;
    logic        held_nxt;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (cs_s) begin
            state_nxt = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (hold_fall && !quad_mode)
                        state_nxt = sck_s ? ST_START_WAIT : ST_HELD;
                end
                ST_START_WAIT: begin
                    if (hold_rise)     state_nxt = ST_RUN;
                    else if (sck_fall) state_nxt = ST_HELD;
                end
                ST_HELD: begin
                    if (hold_rise)
                        state_nxt = sck_s ? ST_END_WAIT : ST_RUN;
                end
                ST_END_WAIT: begin
                    if (hold_fall)     state_nxt = ST_HELD;
                    else if (sck_fall) state_nxt = ST_RUN;
                end
                default: state_nxt = ST_RUN;
            endcase
        end
    end

    assign held_nxt = (state_nxt == ST_HELD) || (state_nxt == ST_END_WAIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // Output register: flag and output-enable from one next-state decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_active <= 1'b0;
            sdo_oe      <= 1'b0;
        end else begin
            hold_active <= held_nxt;
            sdo_oe      <= !cs_s && !held_nxt;
        end
    end
endmodule

// File: rtl/sbh_shifter.sv
module sbh_shifter #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sck_rise,
    input  logic              sdi_s,
    input  logic              freeze,
    output logic [WORD_W-1:0] shreg,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (cs_s) begin
                shreg   <= '0;
                bit_cnt <= '0;
            end else if (sck_rise && !freeze) begin
                shreg <= {shreg[WORD_W-2:0], sdi_s};
                if (bit_cnt == LAST) begin
                    bit_cnt  <= '0;
                    rx_byte  <= {shreg[WORD_W-2:0], sdi_s};
                    rx_valid <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sbus_hold_ctrl.sv
module sbus_hold_ctrl
    import sbh_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W      = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n_in,
    input  logic                       sck_in,
    input  logic                       hold_n_in,
    input  logic                       sdi_in,
    input  logic                       quad_mode,
    output logic                       hold_active,
    output logic                       sdo_oe,
    output logic                       sdo_out,
    output logic [$clog2(WORD_W)-1:0]  bit_cnt,
    output logic [WORD_W-1:0]          rx_byte,
    output logic                       rx_valid
);
    logic [3:0]        sync_q;
    logic              cs_s, sck_s, hold_s, sdi_s;
    logic              sck_prev, hold_prev;
    logic              sck_rise, sck_fall, hold_rise, hold_fall;
    hold_state_t       state;
    logic [WORD_W-1:0] shreg;

    // Inputs packed as {sdi, hold_n, sck, cs_n}; idle: deselected, clock low, no hold
    sbh_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sdi_in, hold_n_in, sck_in, cs_n_in}),
        .d_out (sync_q)
    );
    assign {sdi_s, hold_s, sck_s, cs_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev  <= 1'b0;
            hold_prev <= 1'b1;
        end else begin
            sck_prev  <= sck_s;
            hold_prev <= hold_s;
        end
    end

    assign sck_rise  = !sck_prev && sck_s;
    assign sck_fall  = sck_prev && !sck_s;
    assign hold_rise = !hold_prev && hold_s;
    assign hold_fall = hold_prev && !hold_s;

    sbh_hold_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .sck_s       (sck_s),
        .sck_fall    (sck_fall),
        .hold_fall   (hold_fall),
        .hold_rise   (hold_rise),
        .quad_mode   (quad_mode),
        .state       (state),
        .hold_active (hold_active),
        .sdo_oe      (sdo_oe)
    );

    sbh_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (cs_s),
        .sck_rise (sck_rise),
        .sdi_s    (sdi_s),
        .freeze   (hold_active),
        .shreg    (shreg),
        .bit_cnt  (bit_cnt),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    assign sdo_out = shreg[WORD_W-1];
endmodule

// File: rtl/sbh_checker.sv
module sbh_checker
    import sbh_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_s,
    input logic             quad_mode,
    input hold_state_t      state,
    input logic             hold_active,
    input logic             sdo_oe,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             rx_valid
);
    assert_oe_off_when_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> !sdo_oe);

    assert_cnt_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !cs_s) |=> $stable(bit_cnt));

    assert_no_word_while_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |=> !rx_valid);

    assert_quad_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && quad_mode) |=> (state == ST_RUN));

    assert_deselect_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!hold_active && bit_cnt == '0));

    assert_start_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> $past(!cs_s));
endmodule

bind sbus_hold_ctrl sbh_checker #(.CNT_W($clog2(WORD_W))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .quad_mode   (quad_mode),
    .state       (state),
    .hold_active (hold_active),
    .sdo_oe      (sdo_oe),
    .bit_cnt     (bit_cnt),
    .rx_valid    (rx_valid)
);

// File: tb/sbus_hold_ctrl_test.sv
`timescale 1ns/1ps
module sbus_hold_ctrl_test;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n_in = 1'b1, sck_in = 1'b0, hold_n_in = 1'b1, sdi_in = 1'b0;
    logic       quad_mode = 1'b0;
    logic       hold_active, sdo_oe, sdo_out, rx_valid;
    logic [2:0] bit_cnt;
    logic [7:0] rx_byte;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    sbus_hold_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sck_in(sck_in),
        .hold_n_in(hold_n_in), .sdi_in(sdi_in), .quad_mode(quad_mode),
        .hold_active(hold_active), .sdo_oe(sdo_oe), .sdo_out(sdo_out),
        .bit_cnt(bit_cnt), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rise_bit(input bit b);
        sdi_in = b; waitc(H);
        sck_in = 1'b1; waitc(H);
    endtask

    task automatic fall_sck();
        sck_in = 1'b0; waitc(H);
    endtask

    task automatic send_bits(input logic [7:0] v, input int from, input int to);
        for (int i = from; i <= to; i++) begin
            rise_bit(v[7-i]);
            fall_sck();
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected word", rx_byte, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_byte == e, "R12 word", rx_byte, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        waitc(3);
        rst_n = 1'b1;
        waitc(4);
        chk(hold_active == 0, "R1 hold_active", hold_active, 0);
        chk(sdo_oe == 0, "R1 sdo_oe", sdo_oe, 0);
        chk(bit_cnt == 0, "R1 bit_cnt", bit_cnt, 0);
        chk(rx_valid == 0, "R1 rx_valid", rx_valid, 0);

        cs_n_in = 1'b0; waitc(5);
        chk(sdo_oe == 1, "R7 oe selected", sdo_oe, 1);

        // Plain word
        exp_q.push_back(8'hA5);
        send_bits(8'hA5, 0, 7);
        chk(bit_cnt == 0, "R12 cnt wrap", bit_cnt, 0);

        // R2 / R4 / R6: pause with clock low
        exp_q.push_back(8'h3C);
        send_bits(8'h3C, 0, 2);
        hold_n_in = 1'b0; waitc(4);
        chk(hold_active == 1, "R2 start low clk", hold_active, 1);
        chk(sdo_oe == 0, "R7 oe held", sdo_oe, 0);
        for (int k = 0; k < 4; k++) begin
            rise_bit(k[0]);
            fall_sck();
        end
        chk(bit_cnt == 3, "R6 cnt frozen", bit_cnt, 3);
        chk(hold_active == 1, "R6 still held", hold_active, 1);
        hold_n_in = 1'b1; waitc(4);
        chk(hold_active == 0, "R4 end low clk", hold_active, 0);
        chk(sdo_oe == 1, "R7 oe back", sdo_oe, 1);
        send_bits(8'h3C, 3, 7);

        // R3 / R5: edges with clock high
        exp_q.push_back(8'h96);
        send_bits(8'h96, 0, 1);
        rise_bit(1'b0);
        hold_n_in = 1'b0; waitc(H);
        chk(hold_active == 0, "R3 wait for fall", hold_active, 0);
        fall_sck();
        chk(hold_active == 1, "R3 start at fall", hold_active, 1);
        rise_bit(1'b1);
        hold_n_in = 1'b1; waitc(H);
        chk(hold_active == 1, "R5 still held", hold_active, 1);
        chk(bit_cnt == 3, "R6 cnt frozen 2", bit_cnt, 3);
        fall_sck();
        chk(hold_active == 0, "R5 end at fall", hold_active, 0);
        send_bits(8'h96, 3, 7);

        // R10: cancel pending start
        exp_q.push_back(8'h5A);
        send_bits(8'h5A, 0, 1);
        rise_bit(1'b0);
        hold_n_in = 1'b0; waitc(H);
        hold_n_in = 1'b1; waitc(H);
        fall_sck();
        chk(hold_active == 0, "R10 start cancelled", hold_active, 0);
        chk(bit_cnt == 3, "R10 cnt", bit_cnt, 3);
        send_bits(8'h5A, 3, 7);

        // R11: cancel pending release
        exp_q.push_back(8'hC3);
        send_bits(8'hC3, 0, 3);
        hold_n_in = 1'b0; waitc(4);
        sck_in = 1'b1; waitc(H);
        hold_n_in = 1'b1; waitc(H);
        hold_n_in = 1'b0; waitc(H);
        fall_sck();
        chk(hold_active == 1, "R11 release cancelled", hold_active, 1);
        hold_n_in = 1'b1; waitc(4);
        chk(hold_active == 0, "R11 later release", hold_active, 0);
        chk(bit_cnt == 4, "R6 resume position", bit_cnt, 4);
        send_bits(8'hC3, 4, 7);

        // R8: quad mode
        quad_mode = 1'b1;
        exp_q.push_back(8'h81);
        send_bits(8'h81, 0, 3);
        hold_n_in = 1'b0; waitc(4);
        chk(hold_active == 0, "R8 quad ignore", hold_active, 0);
        chk(sdo_oe == 1, "R8 oe stays", sdo_oe, 1);
        send_bits(8'h81, 4, 7);
        hold_n_in = 1'b1; waitc(4);
        quad_mode = 1'b0;

        // R9: deselect during pause
        send_bits(8'hFF, 0, 2);
        hold_n_in = 1'b0; waitc(4);
        chk(hold_active == 1, "R9 held before", hold_active, 1);
        cs_n_in = 1'b1; waitc(4);
        chk(hold_active == 0, "R9 released", hold_active, 0);
        chk(bit_cnt == 0, "R9 cnt cleared", bit_cnt, 0);
        chk(sdo_oe == 0, "R7 oe deselected", sdo_oe, 0);
        hold_n_in = 1'b1; waitc(4);
        cs_n_in = 1'b0; waitc(4);
        exp_q.push_back(8'h42);
        send_bits(8'h42, 0, 7);

        waitc(4);
        chk(exp_q.size() == 0, "R12 all words seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule